// File: doc/BRIEF.md
# Privileged Trap Routing Unit

This block decides where a trap lands on a 64-bit hart with machine (M), supervisor (S) and user (U) privilege. Each cycle it looks at a synchronous exception request (a 4-bit cause code plus an address) and at the pending interrupt lines. It weighs them against the delegation masks, the interrupt enable masks and the global enable bits of the status word. It then reports whether a trap is taken and whether it goes to S or to M. It also gives the cause word and the trap value for that trap. On the next clock edge it updates the previous-mode and enable fields and the current privilege.

The delegation, enable and pending masks and the status word sit behind a small register port. This port uses a 3-bit select, a write strobe, write data and a read mux with no latency. Return requests, from M or from S, restore the privilege and the interrupt enables. The surrounding pipeline supplies the exception requests and return strobes. It consumes `trap_taken`, `trap_to_s`, `cause_o` and `tval_o` in the same cycle.

Top module: `trap_route_unit`

## Requirements
- R1: After synchronous reset the privilege is M (`priv_o` = 3; U = 0, S = 1). The status word, both delegation masks, the enable mask and the software pending bits are all zero.
- R2: The exception delegation register keeps every written bit except bit 11, which always reads 0. Writing all ones therefore reads back 0xFFFFFFFFFFFFF7FF.
- R3: Register select codes are: 0 machine status, 1 supervisor status, 2 exception delegation, 3 interrupt delegation, 4 machine enable, 5 supervisor enable, 6 machine pending, 7 supervisor pending. Writing all ones to interrupt delegation reads back 0x222. Writing 0xFFFF to machine enable reads back 0xAAA. Supervisor enable reads as machine enable masked to bits 1, 5 and 9.
- R4: A trap raised while the privilege is M always goes to M, whatever the delegation masks hold.
- R5: An exception raised in S or U goes to S when its code's bit is set in exception delegation. Otherwise it goes to M.
- R6: The cause word carries the code in its low bits. Bit 63 is set for interrupts (codes 1, 3, 5, 7, 9, 11) and clear for exceptions (0–9, 11).
- R7: The trap value is the address with bit 0 cleared for code 0. It is the address unchanged for codes 3, 4 and 6. It is zero for every other exception and for interrupts.
- R8: A trap to M sets the previous-mode field (status bits 12:11) to the old privilege. It copies the machine enable (bit 3) into its saved copy (bit 7) and clears bit 3.
- R9: A trap to S sets bit 8 to 1 if it came from S and to 0 if it came from U. It copies the supervisor enable (bit 1) into bit 5, clears bit 1 and sets the privilege to S.
- R10: An undelegated interrupt is taken when it is pending and enabled, and either the privilege is below M or bit 3 is set. A delegated interrupt is taken only in U, or in S with bit 1 set, and never in M.
- R11: Among ready interrupts the order is 11, 3, 7, 9, 1, 5. An exception in the same cycle wins over any interrupt.
- R12: Writes to machine registers (selects 0, 2, 3, 4, 6) are ignored below M. Writes to supervisor registers (1, 5, 7) are ignored in U, so U cannot raise supervisor software pending (bit 1).
- R13: A return from M, accepted only in M, moves to the saved mode. It sets bit 3 from bit 7, sets bit 7, and resets the saved mode to U. A return from S, accepted in S or M, moves to S or U according to bit 8. It sets bit 1 from bit 5, sets bit 5 and clears bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Synchronous exception request this cycle |
| exc_code | input | 4 | Exception cause code |
| exc_addr | input | 64 | Faulting or target address of the exception |
| hw_irq | input | 12 | Platform pending lines; bits 3, 7, 9, 11 used |
| ret_valid | input | 1 | Trap return request |
| ret_is_s | input | 1 | 1 = return from S, 0 = return from M |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select (codes in R3) |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Selected register value, combinational |
| trap_taken | output | 1 | A trap is taken this cycle |
| trap_to_s | output | 1 | Taken trap targets S (else M) |
| cause_o | output | 64 | Cause word of the taken trap |
| tval_o | output | 64 | Trap value of the taken trap |
| priv_o | output | 2 | Current privilege |

## Verification
The hardest case to reach is a delegated interrupt that is pending while the hart sits in M. In that state it must stay dormant, and it must fire as soon as a return drops the hart into U. The stimulus sets the supervisor software bit from M through the machine pending register. It then sets the saved mode to U and issues a return from M. This places the hart in U with the bit already pending. After the trap the hart is in S with its enable cleared, so the bench next shows that the same pending bit is now held off. It clears the bit from S and returns to U. Finally it shows that a write from U to the supervisor pending register leaves the bit clear.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;

    parameter int XLEN  = 64;
    parameter int NIRQ  = 12;
    parameter int CODEW = 4;
    parameter int STW   = 16;
    parameter int NPRIO = 6;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        SEL_MSTAT  = 3'd0,
        SEL_SSTAT  = 3'd1,
        SEL_EDELEG = 3'd2,
        SEL_IDELEG = 3'd3,
        SEL_MEN    = 3'd4,
        SEL_SEN    = 3'd5,
        SEL_MPEND  = 3'd6,
        SEL_SPEND  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        priv_e mpp;
        logic  spp;
        logic  mpie;
        logic  spie;
        logic  mie;
        logic  sie;
    } status_t;

    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;

    localparam int NOCALL_M_CODE = 11;

    localparam logic [NIRQ-1:0] SINT_MASK = 12'h222;
    localparam logic [NIRQ-1:0] EN_MASK   = 12'hAAA;
    localparam logic [NIRQ-1:0] HW_MASK   = 12'hA88;
    localparam logic [STW-1:0]  SVIEW     = 16'h0122;

    // Highest priority first
    localparam int IRQ_ORDER [NPRIO] = '{11, 3, 7, 9, 1, 5};

    function automatic logic [STW-1:0] status_word(input status_t s);
        logic [STW-1:0] w;
        w = '0;
        w[B_SIE]           = s.sie;
        w[B_MIE]           = s.mie;
        w[B_SPIE]          = s.spie;
        w[B_MPIE]          = s.mpie;
        w[B_SPP]           = s.spp;
        w[B_MPP+1:B_MPP]   = s.mpp;
        return w;
    endfunction

    function automatic status_t status_from(input logic [STW-1:0] w);
        status_t s;
        s.sie  = w[B_SIE];
        s.mie  = w[B_MIE];
        s.spie = w[B_SPIE];
        s.mpie = w[B_MPIE];
        s.spp  = w[B_SPP];
        // Reserved encoding 2 folds to U
        s.mpp  = (w[B_MPP+1:B_MPP] == 2'b10) ? PRIV_U : priv_e'(w[B_MPP+1:B_MPP]);
        return s;
    endfunction

endpackage

// File: rtl/trap_route_irq_sel.sv
module trap_route_irq_sel
    import trap_route_pkg::*;
(
    input  logic [NIRQ-1:0]  pend,
    input  logic [NIRQ-1:0]  en,
    input  logic [NIRQ-1:0]  deleg,
    input  priv_e            priv,
    input  logic             m_ie,
    input  logic             s_ie,
    output logic             irq_valid,
    output logic             irq_to_s,
    output logic [CODEW-1:0] irq_code
);

    logic            m_open;
    logic            s_open;
    logic [NIRQ-1:0] ready;

    assign m_open = (priv != PRIV_M) || m_ie;
    assign s_open = (priv == PRIV_U) || ((priv == PRIV_S) && s_ie);

    for (genvar i = 0; i < NIRQ; i++) begin : g_ready
        assign ready[i] = pend[i] && en[i] && (deleg[i] ? s_open : m_open);
    end

    always_comb begin
        irq_valid = 1'b0;
        irq_to_s  = 1'b0;
        irq_code  = '0;
        // Walk lowest priority first so the highest ready one wins
        for (int k = NPRIO - 1; k >= 0; k--) begin
            if (ready[IRQ_ORDER[k]]) begin
                irq_valid = 1'b1;
                irq_to_s  = deleg[IRQ_ORDER[k]];
                irq_code  = CODEW'(IRQ_ORDER[k]);
            end
        end
    end

endmodule

// File: rtl/trap_route_exc.sv
module trap_route_exc
    import trap_route_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [CODEW-1:0] code,
    input  logic [W-1:0]     addr,
    input  logic [W-1:0]     edeleg,
    input  priv_e            priv,
    output logic             to_s,
    output logic [W-1:0]     tval
);

    assign to_s = (priv != PRIV_M) && edeleg[code];

    always_comb begin
        case (code)
            4'd0:                tval = {addr[W-1:1], 1'b0};
            4'd3, 4'd4, 4'd6:    tval = addr;
            default:             tval = '0;
        endcase
    end

endmodule

// File: rtl/trap_route_state.sv
module trap_route_state
    import trap_route_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            take_s,
    input  logic            ret_valid,
    input  logic            ret_is_s,
    input  logic            we,
    input  reg_sel_e        sel,
    input  logic [W-1:0]    wdata,
    output priv_e           priv_q,
    output status_t         st_q,
    output logic [W-1:0]    edeleg_q,
    output logic [NIRQ-1:0] ideleg_q,
    output logic [NIRQ-1:0] en_q,
    output logic [NIRQ-1:0] swpend_q
);

    localparam logic [W-1:0] EDELEG_MASK = ~(W'(1) << NOCALL_M_CODE);

    logic m_wr;
    logic s_wr;

    assign m_wr = (priv_q == PRIV_M);
    assign s_wr = (priv_q != PRIV_U);

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q   <= PRIV_M;
            st_q     <= '0;
            edeleg_q <= '0;
            ideleg_q <= '0;
            en_q     <= '0;
            swpend_q <= '0;
        end else if (take) begin
            if (take_s) begin
                st_q.spp  <= (priv_q == PRIV_S);
                st_q.spie <= st_q.sie;
                st_q.sie  <= 1'b0;
                priv_q    <= PRIV_S;
            end else begin
                st_q.mpp  <= priv_q;
                st_q.mpie <= st_q.mie;
                st_q.mie  <= 1'b0;
                priv_q    <= PRIV_M;
            end
        end else if (ret_valid && !ret_is_s && m_wr) begin
            priv_q    <= st_q.mpp;
            st_q.mie  <= st_q.mpie;
            st_q.mpie <= 1'b1;
            st_q.mpp  <= PRIV_U;
        end else if (ret_valid && ret_is_s && s_wr) begin
            priv_q    <= st_q.spp ? PRIV_S : PRIV_U;
            st_q.sie  <= st_q.spie;
            st_q.spie <= 1'b1;
            st_q.spp  <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_MSTAT:  if (m_wr) st_q <= status_from(wdata[STW-1:0]);
                SEL_SSTAT:  if (s_wr) begin
                    st_q.sie  <= wdata[B_SIE];
                    st_q.spie <= wdata[B_SPIE];
                    st_q.spp  <= wdata[B_SPP];
                end
                SEL_EDELEG: if (m_wr) edeleg_q <= wdata & EDELEG_MASK;
                SEL_IDELEG: if (m_wr) ideleg_q <= wdata[NIRQ-1:0] & SINT_MASK;
                SEL_MEN:    if (m_wr) en_q <= wdata[NIRQ-1:0] & EN_MASK;
                SEL_SEN:    if (s_wr) en_q <= (en_q & ~SINT_MASK) | (wdata[NIRQ-1:0] & SINT_MASK);
                SEL_MPEND:  if (m_wr) swpend_q <= wdata[NIRQ-1:0] & SINT_MASK;
                SEL_SPEND:  if (s_wr) swpend_q[B_SIE] <= wdata[B_SIE];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
    import trap_route_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_valid,
    input  logic [CODEW-1:0] exc_code,
    input  logic [W-1:0]     exc_addr,
    input  logic [NIRQ-1:0]  hw_irq,
    input  logic             ret_valid,
    input  logic             ret_is_s,
    input  logic             csr_we,
    input  logic [2:0]       csr_sel,
    input  logic [W-1:0]     csr_wdata,
    output logic [W-1:0]     csr_rdata,
    output logic             trap_taken,
    output logic             trap_to_s,
    output logic [W-1:0]     cause_o,
    output logic [W-1:0]     tval_o,
    output logic [1:0]       priv_o
);

    localparam logic [W-1:0] IRQ_FLAG = {1'b1, {(W-1){1'b0}}};

    reg_sel_e         sel;
    priv_e            priv;
    status_t          st;
    logic [W-1:0]     edeleg;
    logic [NIRQ-1:0]  ideleg;
    logic [NIRQ-1:0]  en;
    logic [NIRQ-1:0]  swpend;
    logic [NIRQ-1:0]  pend;
    logic             irq_valid;
    logic             irq_to_s;
    logic [CODEW-1:0] irq_code;
    logic             exc_to_s;
    logic [W-1:0]     exc_tval;

    assign sel  = reg_sel_e'(csr_sel);
    assign pend = swpend | (hw_irq & HW_MASK);

    trap_route_state #(.W(W)) state_i (
        .clk      (clk),
        .rst      (rst),
        .take     (trap_taken),
        .take_s   (trap_to_s),
        .ret_valid(ret_valid),
        .ret_is_s (ret_is_s),
        .we       (csr_we),
        .sel      (sel),
        .wdata    (csr_wdata),
        .priv_q   (priv),
        .st_q     (st),
        .edeleg_q (edeleg),
        .ideleg_q (ideleg),
        .en_q     (en),
        .swpend_q (swpend)
    );

    trap_route_irq_sel irq_i (
        .pend     (pend),
        .en       (en),
        .deleg    (ideleg),
        .priv     (priv),
        .m_ie     (st.mie),
        .s_ie     (st.sie),
        .irq_valid(irq_valid),
        .irq_to_s (irq_to_s),
        .irq_code (irq_code)
    );

    trap_route_exc #(.W(W)) exc_i (
        .code  (exc_code),
        .addr  (exc_addr),
        .edeleg(edeleg),
        .priv  (priv),
        .to_s  (exc_to_s),
        .tval  (exc_tval)
    );

    // Exceptions win over interrupts
    assign trap_taken = exc_valid || irq_valid;
    assign trap_to_s  = exc_valid ? exc_to_s : irq_to_s;
    assign tval_o     = exc_valid ? exc_tval : '0;
    assign priv_o     = priv;

    always_comb begin
        if (exc_valid)      cause_o = W'(exc_code);
        else if (irq_valid) cause_o = IRQ_FLAG | W'(irq_code);
        else                cause_o = '0;
    end

    always_comb begin
        case (sel)
            SEL_MSTAT:  csr_rdata = W'(status_word(st));
            SEL_SSTAT:  csr_rdata = W'(status_word(st) & SVIEW);
            SEL_EDELEG: csr_rdata = edeleg;
            SEL_IDELEG: csr_rdata = W'(ideleg);
            SEL_MEN:    csr_rdata = W'(en);
            SEL_SEN:    csr_rdata = W'(en & SINT_MASK);
            SEL_MPEND:  csr_rdata = W'(pend);
            SEL_SPEND:  csr_rdata = W'(pend & SINT_MASK);
            default:    csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trap_route_chk.sv
module trap_route_chk
    import trap_route_pkg::*;
#(
    parameter int W = XLEN
) (
    input logic             clk,
    input logic             rst,
    input logic             trap_taken,
    input logic             trap_to_s,
    input logic             exc_valid,
    input logic [CODEW-1:0] exc_code,
    input logic             ret_valid,
    input logic             ret_is_s,
    input logic [W-1:0]     cause_o,
    input logic [W-1:0]     tval_o,
    input logic [1:0]       priv_o,
    input logic             m_ie,
    input logic             s_ie
);

    a_r4_m_trap_stays_m: assert property (@(posedge clk) disable iff (rst)
        trap_taken && priv_o == 2'd3 |-> !trap_to_s);

    a_r8_m_entry: assert property (@(posedge clk) disable iff (rst)
        trap_taken && !trap_to_s |=> priv_o == 2'd3 && !m_ie);

    a_r9_s_entry: assert property (@(posedge clk) disable iff (rst)
        trap_taken && trap_to_s |=> priv_o == 2'd1 && !s_ie);

    a_r6_irq_flag: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> cause_o[W-1] == !exc_valid);

    a_r7_ecall_tval_zero: assert property (@(posedge clk) disable iff (rst)
        trap_taken && exc_valid && (exc_code == 4'd8 || exc_code == 4'd9 || exc_code == 4'd11)
        |-> tval_o == '0);

    a_r10_m_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        trap_taken && !exc_valid && priv_o == 2'd3 |-> m_ie);

    a_r13_sret_below_m: assert property (@(posedge clk) disable iff (rst)
        ret_valid && ret_is_s && priv_o == 2'd1 && !trap_taken |=> priv_o != 2'd3);

endmodule

bind trap_route_unit trap_route_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .trap_taken(trap_taken),
    .trap_to_s (trap_to_s),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .ret_valid (ret_valid),
    .ret_is_s  (ret_is_s),
    .cause_o   (cause_o),
    .tval_o    (tval_o),
    .priv_o    (priv_o),
    .m_ie      (st.mie),
    .s_ie      (st.sie)
);

// File: tb/trap_route_unit_tb.sv
module trap_route_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_valid;
    logic [3:0]  exc_code;
    logic [63:0] exc_addr;
    logic [11:0] hw_irq;
    logic        ret_valid;
    logic        ret_is_s;
    logic        csr_we;
    logic [2:0]  csr_sel;
    logic [63:0] csr_wdata;
    logic [63:0] csr_rdata;
    logic        trap_taken;
    logic        trap_to_s;
    logic [63:0] cause_o;
    logic [63:0] tval_o;
    logic [1:0]  priv_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    trap_route_unit dut_i (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_addr(exc_addr), .hw_irq(hw_irq), .ret_valid(ret_valid),
        .ret_is_s(ret_is_s), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_taken(trap_taken),
        .trap_to_s(trap_to_s), .cause_o(cause_o), .tval_o(tval_o), .priv_o(priv_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        deleg;
        logic        sie;
        logic [3:0]  code;
        logic [63:0] addr;
        logic        to_s;
        logic [63:0] tval;
        logic [63:0] status;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b1, 4'd0,  64'h8000_03d3, 1'b0, 64'h8000_03d2, 64'h802},
        '{2'd0, 1'b0, 1'b0, 4'd4,  64'h8000_040d, 1'b0, 64'h8000_040d, 64'h000},
        '{2'd1, 1'b0, 1'b1, 4'd2,  64'h0000_1234, 1'b0, 64'h0,         64'h802},
        '{2'd1, 1'b1, 1'b1, 4'd3,  64'h8000_0404, 1'b1, 64'h8000_0404, 64'h1a0},
        '{2'd0, 1'b1, 1'b1, 4'd6,  64'h8000_0429, 1'b1, 64'h8000_0429, 64'h0a0},
        '{2'd0, 1'b1, 1'b0, 4'd8,  64'h0000_0000, 1'b1, 64'h0,         64'h080},
        '{2'd3, 1'b1, 1'b0, 4'd2,  64'h0000_0040, 1'b0, 64'h0,         64'h1800},
        '{2'd3, 1'b1, 1'b0, 4'd11, 64'h0000_0000, 1'b0, 64'h0,         64'h1800},
        '{2'd1, 1'b1, 1'b0, 4'd9,  64'h0000_0000, 1'b1, 64'h0,         64'h180},
        '{2'd1, 1'b1, 1'b0, 4'd5,  64'h0000_dead, 1'b1, 64'h0,         64'h180}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        exc_valid = 1'b0; exc_code = '0; exc_addr = '0; hw_irq = '0;
        ret_valid = 1'b0; ret_is_s = 1'b0;
        csr_we = 1'b0; csr_sel = '0; csr_wdata = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [63:0] data);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(posedge clk); @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [63:0] data);
        csr_sel = sel;
        #1;
        data = csr_rdata;
    endtask

    task automatic do_ret(input logic s);
        ret_valid = 1'b1; ret_is_s = s;
        @(posedge clk); @(negedge clk);
        ret_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        do_reset();

        // R1 reset state
        #1;
        check("R1 priv", 64'(priv_o), 64'd3);
        check("R1 trap", 64'(trap_taken), 64'd0);
        reg_read(3'd0, rd); check("R1 status", rd, 64'h0);
        reg_read(3'd2, rd); check("R1 edeleg", rd, 64'h0);
        reg_read(3'd4, rd); check("R1 enable", rd, 64'h0);

        // R2/R3 writable masks
        reg_write(3'd2, '1);
        reg_read(3'd2, rd); check("R2 edeleg bit11", rd, 64'hFFFF_FFFF_FFFF_F7FF);
        reg_write(3'd3, '1);
        reg_read(3'd3, rd); check("R3 ideleg mask", rd, 64'h222);
        reg_write(3'd4, 64'hFFFF);
        reg_read(3'd4, rd); check("R3 enable mask", rd, 64'hAAA);
        reg_read(3'd5, rd); check("R3 sup enable view", rd, 64'h222);

        // Table walk: exceptions R4 R5 R6 R7 R8 R9 R13
        for (int v = 0; v < NV; v++) begin
            do_reset();
            if (VECS[v].deleg) begin
                reg_write(3'd2, '1);
                reg_write(3'd3, '1);
            end
            if (VECS[v].mode != 2'd3 || VECS[v].sie)
                reg_write(3'd0, (64'(VECS[v].mode) << 11) | (64'(VECS[v].sie) << 1));
            if (VECS[v].mode != 2'd3) begin
                do_ret(1'b0);
                #1;
                check("R13 mret target", 64'(priv_o), 64'(VECS[v].mode));
            end
            exc_valid = 1'b1; exc_code = VECS[v].code; exc_addr = VECS[v].addr;
            #1;
            check("R5 taken", 64'(trap_taken), 64'd1);
            check("R4 R5 target", 64'(trap_to_s), 64'(VECS[v].to_s));
            check("R6 cause", cause_o, 64'(VECS[v].code));
            check("R7 tval", tval_o, VECS[v].tval);
            @(posedge clk); @(negedge clk);
            exc_valid = 1'b0;
            reg_read(3'd0, rd);
            check("R8 R9 status", rd, VECS[v].status);
            check("R8 R9 priv", 64'(priv_o), VECS[v].to_s ? 64'd1 : 64'd3);
        end

        // R10 R11 R6 machine interrupts from M
        do_reset();
        reg_write(3'd4, 64'hFFFF);
        hw_irq = 12'h080;
        #1;
        check("R10 held by global enable", 64'(trap_taken), 64'd0);
        hw_irq = 12'h888;
        reg_write(3'd0, 64'h8);
        #1;
        check("R11 top priority", cause_o, 64'h8000_0000_0000_000B);
        check("R6 irq tval", tval_o, 64'h0);
        hw_irq = 12'h088;
        #1;
        check("R11 soft over timer", cause_o, 64'h8000_0000_0000_0003);
        exc_valid = 1'b1; exc_code = 4'd2;
        #1;
        check("R11 exception first", cause_o, 64'h2);
        @(posedge clk); @(negedge clk);
        exc_valid = 1'b0; hw_irq = '0;
        #1;
        check("R8 enable cleared", 64'(trap_taken), 64'd0);

        // R10 delegated interrupt dormant in M, fires in U
        do_reset();
        reg_write(3'd3, '1);
        reg_write(3'd4, 64'hFFFF);
        reg_write(3'd0, 64'h8);
        reg_write(3'd6, 64'h2);
        #1;
        check("R10 delegated held in M", 64'(trap_taken), 64'd0);
        reg_write(3'd0, 64'h8);
        do_ret(1'b0);
        #1;
        check("R13 mret to U", 64'(priv_o), 64'd0);
        check("R10 delegated in U", 64'(trap_to_s & trap_taken), 64'd1);
        check("R6 sup soft cause", cause_o, 64'h8000_0000_0000_0001);
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 now in S", 64'(priv_o), 64'd1);
        check("R10 S needs enable", 64'(trap_taken), 64'd0);

        // R13 sret, R12 U write ignored
        reg_write(3'd7, 64'h0);
        reg_write(3'd1, 64'h20);
        do_ret(1'b1);
        #1;
        check("R13 sret to U", 64'(priv_o), 64'd0);
        reg_read(3'd1, rd); check("R13 sret enables", rd, 64'h22);
        reg_write(3'd7, 64'h2);
        reg_read(3'd7, rd); check("R12 U sip write ignored", rd, 64'h0);
        check("R12 no trap", 64'(trap_taken), 64'd0);
        reg_write(3'd4, 64'h0);
        reg_read(3'd4, rd); check("R12 U enable write ignored", rd, 64'hAAA);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule